// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps instructions in program order while they finish out of order. Each instruction reserves a slot at the tail of a circular buffer when it issues. It is tagged with its destination register, its instruction address, and whether it is a branch or a store. Execution units later write a result and an exception flag into the slot by index. Only the oldest slot can commit, and only once it is complete. A committed slot becomes one of the following: a register write, a store release, or an exception report that empties the whole buffer.

A branch carries its predicted direction into its slot. The slot stays incomplete until the branch is resolved. When the actual outcome differs from the prediction, every younger slot is marked dead. This includes a slot being allocated in that same cycle. Dead slots still leave the head in order, but they produce no architectural effect.

For each source operand of an issuing instruction, the buffer finds the youngest live slot that targets the same register. It reports whether that value already exists and, if so, what it is. Register 0 stands for "no destination" and never matches.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: occupancy is 0, alloc_ready is 1, and no commit output is active.
- R2: An accepted allocation takes the slot given by alloc_idx, which starts at 0 after reset and steps by one modulo 8. alloc_ready is 0 whenever 8 slots are occupied.
- R3: At most one slot retires per cycle, and always the oldest. A slot that is not complete and not dead holds the head, even if younger slots are complete.
- R4: A retiring complete slot without an exception writes its result to its register (cm_reg_we with address and data) when its destination is nonzero. A store slot instead pulses cm_store_rel and never cm_reg_we.
- R5: A complete head slot with its exception flag set raises cm_exc with that slot's instruction address, writes nothing, and leaves the buffer empty on the next cycle. alloc_ready is 0 in that cycle.
- R6: A branch slot cannot retire until br_valid has resolved it.
- R7: A resolution whose br_taken differs from the slot's prediction kills every younger slot, including one allocated in the same cycle. Killed slots retire in order with cm_reg_we and cm_store_rel both 0.
- R8: A resolution that matches the prediction kills nothing, so younger slots later commit normally.
- R9: For a nonzero source register, fwd_hit reports a live slot with that destination, and fwd_idx names the youngest such slot. fwd_ready reports that this slot is complete, and fwd_data then carries its result.
- R10: occupancy equals allocations minus retirements since the last reset or exception flush, and never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a slot this cycle |
| alloc_rd | input | 5 | Destination register, 0 for none |
| alloc_pc | input | 32 | Instruction address |
| alloc_is_br | input | 1 | Slot is a branch |
| alloc_pred | input | 1 | Predicted branch direction |
| alloc_is_st | input | 1 | Slot is a store |
| alloc_ready | output | 1 | A slot can be granted |
| alloc_idx | output | 3 | Index of the slot granted now |
| cmpl_valid | input | 1 | Execution result arrives |
| cmpl_idx | input | 3 | Slot of the result |
| cmpl_data | input | 32 | Result value |
| cmpl_exc | input | 1 | Result carries an exception |
| br_valid | input | 1 | Branch outcome arrives |
| br_idx | input | 3 | Slot of the branch |
| br_taken | input | 1 | Actual branch direction |
| src_rd | input | 10 | Two source registers, source 0 in the low bits |
| fwd_hit | output | 2 | Per source, a live producer exists |
| fwd_ready | output | 2 | Per source, the producer is complete |
| fwd_idx | output | 6 | Per source, slot of the youngest producer |
| fwd_data | output | 64 | Per source, producer result |
| cm_retire | output | 1 | Head slot leaves this cycle |
| cm_reg_we | output | 1 | Register write at commit |
| cm_reg_addr | output | 5 | Register written |
| cm_reg_data | output | 32 | Value written |
| cm_store_rel | output | 1 | Store released at commit |
| cm_exc | output | 1 | Exception reported, buffer flushed |
| cm_exc_pc | output | 32 | Address of the faulting instruction |
| occupancy | output | 4 | Number of occupied slots |

## Verification
The checks assume well-formed inputs. cmpl_idx always names an occupied non-branch slot that has not yet completed. br_idx names an occupied, live branch slot that has not been resolved, and that slot never receives a completion. Branches and stores are allocated with destination 0. The random stimulus draws each completion and resolution target from a model of the occupied slots and skips any draw that breaks these rules. Under these conditions the only illegal allocation is one made while alloc_ready is low, and the hardware refuses that itself.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int ROB_DEPTH = 8;
    localparam int ROB_IDX_W = $clog2(ROB_DEPTH);
    localparam int ROB_CNT_W = ROB_IDX_W + 1;
    localparam int REG_W     = 5;
    localparam int XLEN      = 32;
    localparam int NSRC      = 2;

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  data;
        logic             done;
        logic             exc;
        logic             dead;
        logic             is_br;
        logic             pred;
        logic             is_st;
    } slot_t;

    typedef struct packed {
        slot_t [ROB_DEPTH-1:0] slot;
        logic [ROB_IDX_W-1:0]  head;
        logic [ROB_CNT_W-1:0]  cnt;
    } rob_state_t;
endpackage

// File: rtl/rob_younger_mask.sv
module rob_younger_mask #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] cnt,
    input  logic [IDX_W-1:0] ref_idx,
    output logic [DEPTH-1:0] occupied,
    output logic [DEPTH-1:0] younger
);
    logic [IDX_W-1:0] ref_age;
    assign ref_age = ref_idx - head;

    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        logic [IDX_W-1:0] age;
        assign age         = IDX_W'(i) - head;
        assign occupied[i] = {1'b0, age} < cnt;
        assign younger[i]  = occupied[i] && (age > ref_age);
    end
endmodule

// File: rtl/rob_fwd_search.sv
module rob_fwd_search #(
    parameter int DEPTH = 8,
    parameter int REG_W = 5,
    parameter int XLEN  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]            head,
    input  logic [DEPTH-1:0]            live,
    input  logic [DEPTH-1:0]            done,
    input  logic [DEPTH-1:0][REG_W-1:0] rd,
    input  logic [DEPTH-1:0][XLEN-1:0]  data,
    input  logic [REG_W-1:0]            src,
    output logic                        hit,
    output logic                        ready,
    output logic [IDX_W-1:0]            idx,
    output logic [XLEN-1:0]             value
);
    always_comb begin
        hit   = 1'b0;
        ready = 1'b0;
        idx   = '0;
        value = '0;
        // walk oldest to youngest; a later match overrides an earlier one
        for (int k = 0; k < DEPTH; k++) begin
            logic [IDX_W-1:0] p;
            p = head + IDX_W'(k);
            if (live[p] && src != '0 && rd[p] == src) begin
                hit   = 1'b1;
                ready = done[p];
                idx   = p;
                value = done[p] ? data[p] : '0;
            end
        end
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_valid,
    input  logic [REG_W-1:0]          alloc_rd,
    input  logic [XLEN-1:0]           alloc_pc,
    input  logic                      alloc_is_br,
    input  logic                      alloc_pred,
    input  logic                      alloc_is_st,
    output logic                      alloc_ready,
    output logic [ROB_IDX_W-1:0]      alloc_idx,
    input  logic                      cmpl_valid,
    input  logic [ROB_IDX_W-1:0]      cmpl_idx,
    input  logic [XLEN-1:0]           cmpl_data,
    input  logic                      cmpl_exc,
    input  logic                      br_valid,
    input  logic [ROB_IDX_W-1:0]      br_idx,
    input  logic                      br_taken,
    input  logic [NSRC*REG_W-1:0]     src_rd,
    output logic [NSRC-1:0]           fwd_hit,
    output logic [NSRC-1:0]           fwd_ready,
    output logic [NSRC*ROB_IDX_W-1:0] fwd_idx,
    output logic [NSRC*XLEN-1:0]      fwd_data,
    output logic                      cm_retire,
    output logic                      cm_reg_we,
    output logic [REG_W-1:0]          cm_reg_addr,
    output logic [XLEN-1:0]           cm_reg_data,
    output logic                      cm_store_rel,
    output logic                      cm_exc,
    output logic [XLEN-1:0]           cm_exc_pc,
    output logic [ROB_CNT_W-1:0]      occupancy
);
    rob_state_t st_q, st_d;

    logic [ROB_DEPTH-1:0] occ_mask, kill_mask;
    logic [ROB_DEPTH-1:0] live_v, done_v;
    logic [ROB_DEPTH-1:0][REG_W-1:0] rd_v;
    logic [ROB_DEPTH-1:0][XLEN-1:0]  data_v;

    rob_younger_mask #(.DEPTH(ROB_DEPTH)) u_age (
        .head     (st_q.head),
        .cnt      (st_q.cnt),
        .ref_idx  (br_idx),
        .occupied (occ_mask),
        .younger  (kill_mask)
    );

    for (genvar i = 0; i < ROB_DEPTH; i++) begin : g_view
        assign live_v[i] = occ_mask[i] && !st_q.slot[i].dead;
        assign done_v[i] = st_q.slot[i].done;
        assign rd_v[i]   = st_q.slot[i].rd;
        assign data_v[i] = st_q.slot[i].data;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_fwd
        rob_fwd_search #(
            .DEPTH (ROB_DEPTH),
            .REG_W (REG_W),
            .XLEN  (XLEN)
        ) u_search (
            .head  (st_q.head),
            .live  (live_v),
            .done  (done_v),
            .rd    (rd_v),
            .data  (data_v),
            .src   (src_rd[s*REG_W +: REG_W]),
            .hit   (fwd_hit[s]),
            .ready (fwd_ready[s]),
            .idx   (fwd_idx[s*ROB_IDX_W +: ROB_IDX_W]),
            .value (fwd_data[s*XLEN +: XLEN])
        );
    end

    slot_t                h_slot;
    logic                 nonempty, flush, pop, grant, mispred;
    logic [ROB_IDX_W-1:0] tail;

    always_comb begin
        st_d     = st_q;
        h_slot   = st_q.slot[st_q.head];
        nonempty = st_q.cnt != '0;
        tail     = st_q.head + st_q.cnt[ROB_IDX_W-1:0];
        flush    = nonempty && !h_slot.dead && h_slot.done && h_slot.exc;
        pop      = nonempty && (h_slot.dead || h_slot.done);
        mispred  = br_valid && (br_taken != st_q.slot[br_idx].pred);

        alloc_ready = (st_q.cnt != ROB_CNT_W'(ROB_DEPTH)) && !flush;
        alloc_idx   = tail;
        grant       = alloc_valid && alloc_ready;

        cm_retire    = pop;
        cm_exc       = flush;
        cm_exc_pc    = flush ? h_slot.pc : '0;
        cm_reg_we    = pop && !h_slot.dead && !h_slot.exc && !h_slot.is_br
                       && !h_slot.is_st && h_slot.rd != '0;
        cm_reg_addr  = cm_reg_we ? h_slot.rd : '0;
        cm_reg_data  = cm_reg_we ? h_slot.data : '0;
        cm_store_rel = pop && !h_slot.dead && !h_slot.exc && h_slot.is_st;
        occupancy    = st_q.cnt;

        if (flush) begin
            st_d.head = tail;
            st_d.cnt  = '0;
        end else begin
            if (cmpl_valid) begin
                st_d.slot[cmpl_idx].done = 1'b1;
                st_d.slot[cmpl_idx].data = cmpl_data;
                st_d.slot[cmpl_idx].exc  = cmpl_exc;
            end
            if (br_valid) begin
                st_d.slot[br_idx].done = 1'b1;
            end
            if (mispred) begin
                for (int i = 0; i < ROB_DEPTH; i++) begin
                    if (kill_mask[i]) st_d.slot[i].dead = 1'b1;
                end
            end
            if (grant) begin
                st_d.slot[tail].rd    = alloc_rd;
                st_d.slot[tail].pc    = alloc_pc;
                st_d.slot[tail].data  = '0;
                st_d.slot[tail].done  = 1'b0;
                st_d.slot[tail].exc   = 1'b0;
                st_d.slot[tail].dead  = mispred;
                st_d.slot[tail].is_br = alloc_is_br;
                st_d.slot[tail].pred  = alloc_pred;
                st_d.slot[tail].is_st = alloc_is_st;
            end
            if (pop) st_d.head = st_q.head + 1'b1;
            st_d.cnt = st_q.cnt + ROB_CNT_W'(grant) - ROB_CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk
    import rob_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_ready,
    input logic [NSRC-1:0]      fwd_hit,
    input logic [NSRC-1:0]      fwd_ready,
    input logic                 cm_retire,
    input logic                 cm_reg_we,
    input logic                 cm_store_rel,
    input logic                 cm_exc,
    input logic [ROB_CNT_W-1:0] occupancy
);
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy == ROB_CNT_W'(ROB_DEPTH) |-> !alloc_ready); // R2
    AST_EFFECT_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_reg_we || cm_store_rel || cm_exc) |-> cm_retire); // R3
    AST_SINGLE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cm_reg_we, cm_store_rel, cm_exc}) <= 1); // R4
    AST_EXC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cm_exc |=> occupancy == '0); // R5
    AST_EXC_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        cm_exc |-> !alloc_ready); // R5
    AST_READY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_ready & ~fwd_hit) == '0); // R9
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= ROB_CNT_W'(ROB_DEPTH)); // R10
    AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cm_exc |=> occupancy <= $past(occupancy) + 1'b1); // R10
endmodule

bind rob_core rob_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_ready  (alloc_ready),
    .fwd_hit      (fwd_hit),
    .fwd_ready    (fwd_ready),
    .cm_retire    (cm_retire),
    .cm_reg_we    (cm_reg_we),
    .cm_store_rel (cm_store_rel),
    .cm_exc       (cm_exc),
    .occupancy    (occupancy)
);

// File: tb/rob_core_tb.sv
module rob_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        alloc_valid = 0, alloc_is_br = 0, alloc_pred = 0, alloc_is_st = 0;
    logic [4:0]  alloc_rd = 0;
    logic [31:0] alloc_pc = 0;
    logic        alloc_ready;
    logic [2:0]  alloc_idx;
    logic        cmpl_valid = 0, cmpl_exc = 0;
    logic [2:0]  cmpl_idx = 0;
    logic [31:0] cmpl_data = 0;
    logic        br_valid = 0, br_taken = 0;
    logic [2:0]  br_idx = 0;
    logic [9:0]  src_rd = 0;
    logic [1:0]  fwd_hit, fwd_ready;
    logic [5:0]  fwd_idx;
    logic [63:0] fwd_data;
    logic        cm_retire, cm_reg_we, cm_store_rel, cm_exc;
    logic [4:0]  cm_reg_addr;
    logic [31:0] cm_reg_data, cm_exc_pc;
    logic [3:0]  occupancy;

    rob_core u_dut (.*);

    int n_chk = 0, n_fail = 0;

    // reference model
    logic [4:0]  m_rd [D];
    logic [31:0] m_pc [D], m_data [D];
    logic        m_done [D], m_exc [D], m_dead [D], m_br [D], m_pred [D], m_st [D], m_ok [D];
    int m_head = 0, m_cnt = 0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int slot_at(int k);
        return (m_head + k) % D;
    endfunction

    function automatic int youngest(logic [4:0] src);
        int r = -1;
        for (int k = 0; k < m_cnt; k++)
            if (!m_dead[slot_at(k)] && src != 0 && m_rd[slot_at(k)] == src) r = slot_at(k);
        return r;
    endfunction

    task automatic step();
        int h;
        bit flush, pop, we, stl, grant, mis;
        string rtag;
        #1;
        h     = m_head;
        flush = m_cnt > 0 && !m_dead[h] && m_done[h] && m_exc[h];
        pop   = m_cnt > 0 && (m_dead[h] || m_done[h]);
        we    = pop && !m_dead[h] && !m_exc[h] && !m_br[h] && !m_st[h] && m_rd[h] != 0;
        stl   = pop && !m_dead[h] && !m_exc[h] && m_st[h];
        rtag  = m_cnt == 0 ? "R3" : m_dead[h] ? "R7" : m_br[h] ? (m_ok[h] ? "R8" : "R6") : "R3";
        check("R10 occupancy", occupancy, m_cnt);
        check("R2 alloc_ready", alloc_ready, m_cnt < D && !flush);
        check("R2 alloc_idx", alloc_idx, (m_head + m_cnt) % D);
        check({rtag, " retire"}, cm_retire, pop);
        check(m_dead[h] ? "R7 reg_we" : "R4 reg_we", cm_reg_we, we);
        if (we) begin
            check("R4 reg_addr", cm_reg_addr, m_rd[h]);
            check("R4 reg_data", cm_reg_data, m_data[h]);
        end
        check(m_dead[h] ? "R7 store_rel" : "R4 store_rel", cm_store_rel, stl);
        check("R5 exc", cm_exc, flush);
        if (flush) check("R5 exc_pc", cm_exc_pc, m_pc[h]);
        for (int s = 0; s < 2; s++) begin
            int y = youngest(src_rd[s*5 +: 5]);
            check("R9 hit", fwd_hit[s], y >= 0);
            if (y >= 0) begin
                check("R9 idx", fwd_idx[s*3 +: 3], y);
                check("R9 ready", fwd_ready[s], m_done[y]);
                if (m_done[y]) check("R9 data", fwd_data[s*32 +: 32], m_data[y]);
            end
        end
        grant = alloc_valid && m_cnt < D && !flush;
        mis   = br_valid && (br_taken != m_pred[br_idx]);
        @(posedge clk);
        if (flush) begin
            m_head = (m_head + m_cnt) % D;
            m_cnt  = 0;
        end else begin
            if (cmpl_valid) begin
                m_done[cmpl_idx] = 1; m_data[cmpl_idx] = cmpl_data; m_exc[cmpl_idx] = cmpl_exc;
            end
            if (br_valid) begin
                m_done[br_idx] = 1; m_ok[br_idx] = !mis;
            end
            if (mis) begin
                int bo = (br_idx - m_head + D) % D;
                for (int k = bo + 1; k < m_cnt; k++) m_dead[slot_at(k)] = 1;
            end
            if (grant) begin
                int t = (m_head + m_cnt) % D;
                m_rd[t] = alloc_rd; m_pc[t] = alloc_pc; m_data[t] = 0; m_done[t] = 0;
                m_exc[t] = 0; m_dead[t] = mis; m_br[t] = alloc_is_br; m_pred[t] = alloc_pred;
                m_st[t] = alloc_is_st; m_ok[t] = 0;
            end
            if (pop) m_head = (m_head + 1) % D;
            m_cnt = m_cnt + int'(grant) - int'(pop);
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        alloc_valid = 0; cmpl_valid = 0; br_valid = 0; cmpl_exc = 0;
    endtask

    task automatic set_alloc(bit br, bit stv, logic [4:0] rd);
        alloc_valid = 1; alloc_is_br = br; alloc_is_st = stv;
        alloc_rd = (br || stv) ? 5'd0 : rd;
        alloc_pc = $urandom; alloc_pred = $urandom % 2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < D; i++) begin
            m_done[i] = 0; m_exc[i] = 0; m_dead[i] = 0; m_br[i] = 0; m_st[i] = 0;
            m_pred[i] = 0; m_ok[i] = 0; m_rd[i] = 0; m_pc[i] = 0; m_data[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check("R1 occupancy", occupancy, 0);
        check("R1 alloc_ready", alloc_ready, 1);
        check("R1 retire", cm_retire, 0);
        check("R1 exc", cm_exc, 0);
        @(negedge clk);
        // R2 fill all slots, then one refused request
        for (int i = 0; i <= D; i++) begin
            idle_inputs();
            set_alloc(0, 0, 5'(i % 4 + 1));
            src_rd = {5'd2, 5'd1};
            step();
        end
        // R3 complete the youngest first: head must not move
        idle_inputs();
        cmpl_valid = 1; cmpl_idx = 3'(D - 1); cmpl_data = 32'hABCD;
        step();
        idle_inputs();
        step();
        // random mix
        for (int n = 0; n < 4000; n++) begin
            idle_inputs();
            if ($urandom % 3 != 0) begin
                int kind = $urandom % 6;
                set_alloc(kind == 0, kind == 1, 5'($urandom % 8));
            end
            if (m_cnt > 0 && $urandom % 2 == 0) begin
                int c = slot_at($urandom % m_cnt);
                if (!m_br[c] && !m_done[c]) begin
                    cmpl_valid = 1; cmpl_idx = 3'(c); cmpl_data = $urandom;
                    cmpl_exc = ($urandom % 24 == 0);
                end
            end
            if (m_cnt > 0 && $urandom % 2 == 0) begin
                int b = slot_at($urandom % m_cnt);
                if (m_br[b] && !m_done[b] && !m_dead[b]) begin
                    br_valid = 1; br_idx = 3'(b); br_taken = $urandom % 2;
                end
            end
            src_rd = {5'($urandom % 8), 5'($urandom % 8)};
            step();
        end
        idle_inputs();
        finish_run();
    end
endmodule